// File: doc/BRIEF.md
# Float-to-Integer Converter

This block turns one IEEE-754 single-precision operand into a 32-bit integer, either two's-complement signed or unsigned as chosen by a select input. Four rounding modes are offered: nearest with ties to even, toward zero, toward +infinity and toward -infinity. A truncate control overrides the selected mode with toward-zero, so a caller can request C-style conversion without changing the mode setting.

Each conversion is started by a one-cycle strobe. The result and three flags are registered and appear one clock later: invalid (NaN, out-of-range or negative-to-unsigned), inexact (fraction discarded) and input-denormal. Out-of-range values saturate to the limit of the chosen integer type. Nonzero magnitudes below one half follow a dedicated rule, so that directed rounding can still yield one, minus one or an invalid result.

Top module: `f2i_conv`

## Requirements
- R1: While reset is low, out_valid, result and all flags are 0. `out_valid` is high exactly in the cycle after an `in_valid` strobe. Without a strobe, result and flags keep their last values.
- R2: `rnd_mode` encoding: 0 = nearest-even, 1 = toward +infinity, 2 = toward -infinity, 3 = toward zero. A high `force_trunc` makes the conversion use toward zero, whatever `rnd_mode` holds.
- R3: In nearest mode, a discarded fraction above one half rounds the magnitude up. A fraction of exactly one half rounds to the even integer.
- R4: Toward zero never increments the magnitude. Toward +infinity increments it when a nonzero fraction was dropped from a positive input. Toward -infinity does so for a negative input.
- R5: In-range conversions raise inexact exactly when the discarded fraction is nonzero. Inexact is not raised when the result saturates.
- R6: `flag_denorm` is set when the exponent field `in_bits[30:23]` is zero and the mantissa `in_bits[22:0]` is nonzero. The sign is `in_bits[31]`.
- R7: A NaN input (exponent all ones, mantissa nonzero) gives result 0 with invalid, in both signed and unsigned mode.
- R8: Unsigned mode with a biased exponent of 159 or more (including infinities) gives 0xFFFFFFFF for a positive input or 0 for a negative input, and raises invalid.
- R9: In signed mode, a rounded magnitude above 0x7FFFFFFF (positive) or above 0x80000000 (negative) saturates to 0x7FFFFFFF or 0x80000000 and raises invalid. This also covers a biased exponent of 159 or more.
- R10: In unsigned mode, a negative input whose rounded magnitude is nonzero gives 0 and raises invalid. A negative input that rounds to magnitude 0 gives 0 with only inexact. Every negative unsigned conversion returns 0.
- R11: A nonzero magnitude below 0.5 raises inexact. It gives 1 under toward +infinity when positive. Under toward -infinity when negative, it gives 0xFFFFFFFF when signed, or 0 with invalid when unsigned. In every other case it gives 0.
- R12: A zero input of either sign gives 0 and no flags. An in-range negative signed result is the two's complement of its rounded magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Conversion strobe |
| in_bits | input | 32 | Single-precision operand |
| is_signed | input | 1 | 1 = signed result, 0 = unsigned |
| rnd_mode | input | 2 | Rounding mode (see R2) |
| force_trunc | input | 1 | Force toward-zero rounding |
| out_valid | output | 1 | Result valid, one cycle after strobe |
| result | output | 32 | Integer result |
| flag_invalid | output | 1 | Invalid operation |
| flag_inexact | output | 1 | Fraction discarded |
| flag_denorm | output | 1 | Operand was denormal |

## Verification
The bench probes the ties at one half. A converter that rounds half away from zero returns 3 rather than 2 for 2.5, and 0 becomes a spurious 1 at exactly 0.5. It probes the signed limits, where -2^31 is exactly representable: an off-by-one limit wrongly raises invalid there, or lets -(2^31+256) wrap into a positive number. The sub-one-half region under each directed mode and signedness is exercised, along with denormals, which a design that treats them as zero would convert without inexact or without the 1 / -1 directed results. Negative operands in unsigned mode show whether invalid is raised only for a nonzero rounded magnitude and never for -0.5 rounding to zero.

// File: rtl/f2i_pkg.sv
// Shared constants and types for the float-to-integer converter.
// Assumes an IEEE-754 single-precision operand and a 32-bit integer result.
package f2i_pkg;
    localparam int EXP_W    = 8;
    localparam int MAN_W    = 23;
    localparam int BIAS     = 127;
    localparam int INT_W    = 32;
    localparam int FP_W     = 1 + EXP_W + MAN_W;
    localparam int SIG_W    = MAN_W + 1;
    localparam int FIX_W    = 2 * INT_W;            // integer part above, fraction below
    localparam int SH_W     = $clog2(FIX_W);
    localparam int SH_BASE  = BIAS + MAN_W - INT_W; // exponent for a zero alignment shift
    localparam int BIG_EXP  = BIAS + INT_W;         // first exponent that cannot fit
    localparam int HALF_EXP = BIAS - 1;             // exponent of 0.5

    typedef enum logic [1:0] {
        RND_NEAR = 2'd0,
        RND_UP   = 2'd1,
        RND_DOWN = 2'd2,
        RND_ZERO = 2'd3
    } rnd_mode_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] expo;
        logic [SIG_W-1:0] sig;
        logic             is_nan;
        logic             is_denorm;
        logic             nonzero;
        logic             too_big;
        logic             below_half;
    } fp_class_t;
endpackage

// File: rtl/f2i_classify.sv
// Unpacks the operand and sorts it into the classes the converter needs.
// Purely combinational. Denormals get a zero hidden bit; they always land
// in the below-half class, so no normalisation is needed.
module f2i_classify
    import f2i_pkg::*;
(
    input  logic [FP_W-1:0] fp_bits,
    output fp_class_t       cls
);
    logic [EXP_W-1:0] e_fld;
    logic [MAN_W-1:0] m_fld;

    assign e_fld = fp_bits[FP_W-2:MAN_W];
    assign m_fld = fp_bits[MAN_W-1:0];

    // Build the class record from the raw fields.
    always_comb begin
        cls.sign       = fp_bits[FP_W-1];
        cls.expo       = e_fld;
        cls.sig        = {(e_fld != '0), m_fld};
        cls.is_nan     = (&e_fld) && (m_fld != '0);
        cls.is_denorm  = (e_fld == '0) && (m_fld != '0);
        cls.nonzero    = (e_fld != '0) || (m_fld != '0);
        cls.too_big    = (e_fld >= EXP_W'(BIG_EXP));
        cls.below_half = (e_fld <  EXP_W'(HALF_EXP));
    end
endmodule

// File: rtl/f2i_align_round.sv
// Aligns the significand into a fixed-point word (integer half above,
// fraction half below) and applies the rounding increment.
// Assumes the exponent lies between 0.5 and the first out-of-range value;
// outputs are don't-care otherwise and are masked downstream.
module f2i_align_round
    import f2i_pkg::*;
(
    input  logic [SIG_W-1:0] sig,
    input  logic [EXP_W-1:0] expo,
    input  logic             sign,
    input  rnd_mode_e        mode,
    output logic [INT_W:0]   mag,
    output logic             rem_nz
);
    logic [SH_W-1:0]  sh;
    logic [FIX_W-1:0] fixed_w;
    logic [INT_W-1:0] ipart;
    logic [INT_W-1:0] frac;
    logic             half;
    logic             sticky;
    logic             bump;

    assign sh      = SH_W'(expo - EXP_W'(SH_BASE));
    assign fixed_w = FIX_W'(sig) << sh;
    assign ipart   = fixed_w[FIX_W-1:INT_W];
    assign frac    = fixed_w[INT_W-1:0];
    assign half    = frac[INT_W-1];
    assign sticky  = |frac[INT_W-2:0];
    assign rem_nz  = half | sticky;

    // Decide whether the magnitude steps up by one.
    always_comb begin
        unique case (mode)
            RND_NEAR: bump = half && (sticky || ipart[0]);
            RND_UP:   bump = rem_nz && !sign;
            RND_DOWN: bump = rem_nz && sign;
            default:  bump = 1'b0;
        endcase
    end

    assign mag = {1'b0, ipart} + (INT_W+1)'(bump);
endmodule

// File: rtl/f2i_finalize.sv
// Picks the final integer and the invalid/inexact flags from the class
// of the operand, the rounded magnitude and the signedness.
// Purely combinational. The priority is NaN, then below-half, then out-of-range, then in-range.
module f2i_finalize
    import f2i_pkg::*;
(
    input  fp_class_t        cls,
    input  logic             is_signed,
    input  rnd_mode_e        mode,
    input  logic [INT_W:0]   mag,
    input  logic             rem_nz,
    output logic [INT_W-1:0] res,
    output logic             inv,
    output logic             inx
);
    logic [INT_W:0] lim;

    // Signed limit: 2^31 for negative operands, 2^31-1 for positive ones.
    assign lim = {1'b0, cls.sign, {(INT_W-1){~cls.sign}}};

    // Select result and flags by operand class.
    always_comb begin
        res = '0;
        inv = 1'b0;
        inx = 1'b0;
        if (cls.is_nan) begin
            inv = 1'b1;
        end else if (cls.below_half) begin
            if (cls.nonzero) begin
                inx = 1'b1;
                if (mode == RND_UP && !cls.sign) begin
                    res = INT_W'(1);
                end else if (mode == RND_DOWN && cls.sign) begin
                    if (is_signed) res = '1;
                    else           inv = 1'b1;
                end
            end
        end else if (cls.too_big) begin
            inv = 1'b1;
            if (is_signed)      res = lim[INT_W-1:0];
            else if (!cls.sign) res = '1;
        end else if (is_signed) begin
            if (mag > lim) begin
                res = lim[INT_W-1:0];
                inv = 1'b1;
            end else begin
                res = cls.sign ? (~mag[INT_W-1:0] + INT_W'(1)) : mag[INT_W-1:0];
                inx = rem_nz;
            end
        end else if (cls.sign) begin
            if (mag != '0) inv = 1'b1;
            else           inx = rem_nz;
        end else if (mag[INT_W]) begin
            res = '1;
            inv = 1'b1;
        end else begin
            res = mag[INT_W-1:0];
            inx = rem_nz;
        end
    end
endmodule

// File: rtl/f2i_conv.sv
// Float-to-integer converter top: classify, align and round, finalize,
// then register the result one cycle after the strobe.
// Assumes inputs are stable around the clock edge at which in_valid is high.
module f2i_conv
    import f2i_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [FP_W-1:0]  in_bits,
    input  logic             is_signed,
    input  logic [1:0]       rnd_mode,
    input  logic             force_trunc,
    output logic             out_valid,
    output logic [INT_W-1:0] result,
    output logic             flag_invalid,
    output logic             flag_inexact,
    output logic             flag_denorm
);
    fp_class_t        cls;
    rnd_mode_e        mode_eff;
    logic [INT_W:0]   mag;
    logic             rem_nz;
    logic [INT_W-1:0] res_c;
    logic             inv_c;
    logic             inx_c;

    assign mode_eff = force_trunc ? RND_ZERO : rnd_mode_e'(rnd_mode);

    f2i_classify u_class (
        .fp_bits (in_bits),
        .cls     (cls)
    );

    f2i_align_round u_round (
        .sig    (cls.sig),
        .expo   (cls.expo),
        .sign   (cls.sign),
        .mode   (mode_eff),
        .mag    (mag),
        .rem_nz (rem_nz)
    );

    f2i_finalize u_final (
        .cls       (cls),
        .is_signed (is_signed),
        .mode      (mode_eff),
        .mag       (mag),
        .rem_nz    (rem_nz),
        .res       (res_c),
        .inv       (inv_c),
        .inx       (inx_c)
    );

    // Output register: capture on strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            result       <= '0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
            flag_denorm  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result       <= res_c;
                flag_invalid <= inv_c;
                flag_inexact <= inx_c;
                flag_denorm  <= cls.is_denorm;
            end
        end
    end

    // R1
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && !out_valid);
    // R6
    denorm_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_bits[FP_W-2:MAN_W] == '0 && in_bits[MAN_W-1:0] != '0 |=> flag_denorm);
    // R7
    nan_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (&in_bits[FP_W-2:MAN_W]) && in_bits[MAN_W-1:0] != '0
        |=> flag_invalid && result == '0);
    // R10
    neg_unsigned_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !is_signed && in_bits[FP_W-1] |=> result == '0);
    // R9
    signed_pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && is_signed && !in_bits[FP_W-1] |=> !result[INT_W-1]);
    // R12
    zero_no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_bits[FP_W-2:0] == '0
        |=> result == '0 && !flag_invalid && !flag_inexact && !flag_denorm);
endmodule

// File: tb/f2i_conv_tb_top.sv
`timescale 1ns/1ps
module f2i_conv_tb_top;
    localparam logic [1:0] M_NE = 2'd0;
    localparam logic [1:0] M_UP = 2'd1;
    localparam logic [1:0] M_DN = 2'd2;
    localparam logic [1:0] M_TZ = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_bits = '0;
    logic        is_signed = 1'b0;
    logic [1:0]  rnd_mode = '0;
    logic        force_trunc = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_invalid;
    logic        flag_inexact;
    logic        flag_denorm;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    f2i_conv dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_bits      (in_bits),
        .is_signed    (is_signed),
        .rnd_mode     (rnd_mode),
        .force_trunc  (force_trunc),
        .out_valid    (out_valid),
        .result       (result),
        .flag_invalid (flag_invalid),
        .flag_inexact (flag_inexact),
        .flag_denorm  (flag_denorm)
    );

    // Apply one strobe and compare the registered outputs one cycle later.
    task automatic run_vec(input string tag, input logic [31:0] bits, input logic sgn,
                           input logic [1:0] md, input logic tr, input logic [31:0] e_res,
                           input logic e_inv, input logic e_inx, input logic e_den);
        @(negedge clk);
        in_bits = bits; is_signed = sgn; rnd_mode = md; force_trunc = tr; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        n_vec++;
        if (out_valid !== 1'b1 || result !== e_res ||
            {flag_invalid, flag_inexact, flag_denorm} !== {e_inv, e_inx, e_den}) begin
            n_bad++;
            $display("FAIL %s: in=%h got v=%b res=%h inv/inx/den=%b%b%b exp v=1 res=%h inv/inx/den=%b%b%b",
                     tag, bits, out_valid, result, flag_invalid, flag_inexact, flag_denorm,
                     e_res, e_inv, e_inx, e_den);
        end
    endtask

    task automatic t_reset;
        in_valid = 1'b1; in_bits = 32'h4020_0000;
        repeat (3) @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0 || result !== 32'h0 || flag_invalid || flag_inexact || flag_denorm) begin
            n_bad++;
            $display("FAIL R1 reset: got v=%b res=%h exp v=0 res=00000000", out_valid, result);
        end
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_hold;
        run_vec("R1 hold setup", 32'h42C8_0000, 1'b1, M_NE, 1'b0, 32'd100, 0, 0, 0);
        in_bits = 32'hBF80_0000; is_signed = 1'b0;
        repeat (2) @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0 || result !== 32'd100 || flag_invalid) begin
            n_bad++;
            $display("FAIL R1 hold: got v=%b res=%h inv=%b exp v=0 res=00000064 inv=0",
                     out_valid, result, flag_invalid);
        end
    endtask

    task automatic t_nearest;
        run_vec("R3 2.5 tie even",   32'h4020_0000, 1, M_NE, 0, 32'd2, 0, 1, 0);
        run_vec("R3 3.5 tie even",   32'h4060_0000, 1, M_NE, 0, 32'd4, 0, 1, 0);
        run_vec("R3 1.5 tie even",   32'h3FC0_0000, 1, M_NE, 0, 32'd2, 0, 1, 0);
        run_vec("R3 2.75 above",     32'h4030_0000, 1, M_NE, 0, 32'd3, 0, 1, 0);
        run_vec("R3 -2.5 tie even",  32'hC020_0000, 1, M_NE, 0, 32'hFFFF_FFFE, 0, 1, 0);
        run_vec("R3 0.5 to zero",    32'h3F00_0000, 1, M_NE, 0, 32'd0, 0, 1, 0);
    endtask

    task automatic t_directed;
        run_vec("R4 2.5 up",         32'h4020_0000, 1, M_UP, 0, 32'd3, 0, 1, 0);
        run_vec("R4 2.5 down",       32'h4020_0000, 1, M_DN, 0, 32'd2, 0, 1, 0);
        run_vec("R4 -2.5 up",        32'hC020_0000, 1, M_UP, 0, 32'hFFFF_FFFE, 0, 1, 0);
        run_vec("R4 -2.5 down",      32'hC020_0000, 1, M_DN, 0, 32'hFFFF_FFFD, 0, 1, 0);
        run_vec("R4 2.75 zero",      32'h4030_0000, 1, M_TZ, 0, 32'd2, 0, 1, 0);
        run_vec("R2 trunc over up",  32'h4020_0000, 1, M_UP, 1, 32'd2, 0, 1, 0);
        run_vec("R2 trunc over ne",  32'h4030_0000, 0, M_NE, 1, 32'd2, 0, 1, 0);
        run_vec("R5 1.0 exact up",   32'h3F80_0000, 1, M_UP, 0, 32'd1, 0, 0, 0);
    endtask

    task automatic t_unsigned_range;
        run_vec("R8 2^32 sat",       32'h4F80_0000, 0, M_NE, 0, 32'hFFFF_FFFF, 1, 0, 0);
        run_vec("R8 +inf sat",       32'h7F80_0000, 0, M_NE, 0, 32'hFFFF_FFFF, 1, 0, 0);
        run_vec("R8 -2^32 sat",      32'hCF80_0000, 0, M_NE, 0, 32'd0, 1, 0, 0);
        run_vec("R8 1.5*2^31 fits",  32'h4F40_0000, 0, M_NE, 0, 32'hC000_0000, 0, 0, 0);
    endtask

    task automatic t_signed_range;
        run_vec("R9 2^31 sat",       32'h4F00_0000, 1, M_NE, 0, 32'h7FFF_FFFF, 1, 0, 0);
        run_vec("R9 -2^31 exact",    32'hCF00_0000, 1, M_NE, 0, 32'h8000_0000, 0, 0, 0);
        run_vec("R9 below -2^31",    32'hCF00_0001, 1, M_NE, 0, 32'h8000_0000, 1, 0, 0);
        run_vec("R9 -inf sat",       32'hFF80_0000, 1, M_NE, 0, 32'h8000_0000, 1, 0, 0);
        run_vec("R9 max exact",      32'h4EFF_FFFF, 1, M_NE, 0, 32'h7FFF_FF80, 0, 0, 0);
    endtask

    task automatic t_nan;
        run_vec("R7 qnan signed",    32'h7FC0_0000, 1, M_NE, 0, 32'd0, 1, 0, 0);
        run_vec("R7 snan unsigned",  32'h7F80_0001, 0, M_UP, 0, 32'd0, 1, 0, 0);
        run_vec("R7 -qnan unsigned", 32'hFFC0_0000, 0, M_NE, 0, 32'd0, 1, 0, 0);
    endtask

    task automatic t_unsigned_neg;
        run_vec("R10 -1.5 ne",       32'hBFC0_0000, 0, M_NE, 0, 32'd0, 1, 0, 0);
        run_vec("R10 -1.0 zero",     32'hBF80_0000, 0, M_TZ, 0, 32'd0, 1, 0, 0);
        run_vec("R10 -0.5 ne to 0",  32'hBF00_0000, 0, M_NE, 0, 32'd0, 0, 1, 0);
    endtask

    task automatic t_small;
        run_vec("R11 0.25 up",       32'h3E80_0000, 1, M_UP, 0, 32'd1, 0, 1, 0);
        run_vec("R11 0.25 ne",       32'h3E80_0000, 1, M_NE, 0, 32'd0, 0, 1, 0);
        run_vec("R11 0.25 down",     32'h3E80_0000, 1, M_DN, 0, 32'd0, 0, 1, 0);
        run_vec("R11 -0.25 down s",  32'hBE80_0000, 1, M_DN, 0, 32'hFFFF_FFFF, 0, 1, 0);
        run_vec("R11 -0.25 down u",  32'hBE80_0000, 0, M_DN, 0, 32'd0, 1, 1, 0);
        run_vec("R11 -0.25 up",      32'hBE80_0000, 1, M_UP, 0, 32'd0, 0, 1, 0);
        run_vec("R11 0.25 up trunc", 32'h3E80_0000, 0, M_UP, 1, 32'd0, 0, 1, 0);
    endtask

    task automatic t_denorm;
        run_vec("R6 +den up",        32'h0000_0001, 1, M_UP, 0, 32'd1, 0, 1, 1);
        run_vec("R6 -den down",      32'h8000_0001, 1, M_DN, 0, 32'hFFFF_FFFF, 0, 1, 1);
        run_vec("R6 +den zero",      32'h007F_FFFF, 0, M_TZ, 0, 32'd0, 0, 1, 1);
    endtask

    task automatic t_zero_and_neg;
        run_vec("R12 +0",            32'h0000_0000, 1, M_UP, 0, 32'd0, 0, 0, 0);
        run_vec("R12 -0 down",       32'h8000_0000, 1, M_DN, 0, 32'd0, 0, 0, 0);
        run_vec("R12 -1.0",          32'hBF80_0000, 1, M_TZ, 0, 32'hFFFF_FFFF, 0, 0, 0);
        run_vec("R12 -100.0",        32'hC2C8_0000, 1, M_NE, 0, 32'hFFFF_FF9C, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_hold();
        t_nearest();
        t_directed();
        t_unsigned_range();
        t_signed_range();
        t_nan();
        t_unsigned_neg();
        t_small();
        t_denorm();
        t_zero_and_neg();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #20000;
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL R1 watchdog: got no completion, exp completion within 20000 ns");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule